// File: doc/BRIEF.md
# FSK Zero-Crossing Frame Demodulator

This block recovers framed data from a two-tone frequency-shift-keyed carrier that has already been reduced to a one-bit sign stream. Every sample marked valid carries only the polarity of the carrier. The block finds each rising zero crossing and groups the crossings in sixteens. For each group it counts the samples the sixteen carrier cycles took. From that count it decides whether the group was the lower tone (a 1), the higher tone (a 0), or neither.

Decided bits, least significant first, are pushed into a 128-bit right-shifting history. When the bottom of the history holds the frame marker and the frame's opening byte repeats as its closing byte, the block latches a 64-bit payload and a 16-bit check field and raises a one-clock frame pulse. A count that fits neither tone wipes the whole history, so a frame must arrive without a single noisy group. Checking the 16-bit field is left to the consumer.

Top module: `fsk_zc_frame_demod`

## Requirements
- R1: A rising crossing is a valid sample with `sample_neg`=0 whose preceding valid sample had `sample_neg`=1. Every 16th rising crossing closes a measurement. Clock cycles with `sample_valid` low change nothing.
- R2: The measurement is the number of valid samples after the previous closing sample, up to and including the current one. Expected counts are E_lo=(FS_HZ*16)/F_LO_HZ and E_hi=(FS_HZ*16)/F_HI_HZ, with integer division. The tolerance is T=(E_lo-E_hi+1)/2. A count strictly between E_lo-T and E_lo+T decides a 1. With defaults: E_lo=259, E_hi=238, T=11.
- R3: A count strictly between E_hi-T and E_hi+T, and outside the 1 window, decides a 0.
- R4: A count in neither window clears all 128 history bits.
- R5: A decided bit enters at history bit 127 while the history shifts one place toward bit 0, so the first bit sent ends up lowest.
- R6: A frame is accepted when history bits [22:0] equal 23'h7E0000 and history bits [23:16] equal bits [111:104].
- R7: On acceptance, `payload` takes history bits [87:24] and `crc_field` takes history bits [103:88].
- R8: `frame_valid` is high for exactly one clock per acceptance. `payload` and `crc_field` hold their values until the next acceptance.
- R9: The history is cleared when a frame is accepted, so stale bits can never form a second frame.
- R10: The sample counter saturates at 2^CNT_W-1, so an overlong group is judged as noise and never wraps into a window.
- R11: Synchronous active-high `rst` clears the crossing counter, the sample counter, the history and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Marks a cycle that carries a new sign sample |
| sample_neg | input | 1 | Sign of the sample, 1 = negative |
| frame_valid | output | 1 | One-clock pulse on frame acceptance |
| payload | output | 64 | Payload of the last accepted frame |
| crc_field | output | 16 | Check field of the last accepted frame |

## Verification
The decision state is hidden and only shows when a frame is accepted, so internal faults appear late at the ports. A wrong crossing count, a bad window edge or a wrapping counter changes or removes the next frame's payload, at the earliest a few clocks after the 128th bit. Faults in clearing and reset leave stale history that can raise an extra pulse up to one frame length later. The tests therefore place boundary counts inside real frames and then watch for both missing pulses and spurious ones.

// File: rtl/fsk_zc_pkg.sv
package fsk_zc_pkg;

  // history layout (fixed by the frame format)
  localparam int WIN_W     = 128;
  localparam int MARK_W    = 23;
  localparam logic [MARK_W-1:0] SOF_MARK = 23'h7E0000;
  localparam int TAG_W     = 8;
  localparam int HEAD_LSB  = 16;
  localparam int TAIL_LSB  = 104;
  localparam int PAY_LSB   = 24;
  localparam int PAY_W     = 64;
  localparam int CHK_LSB   = PAY_LSB + PAY_W;
  localparam int CHK_W     = 16;

  typedef struct packed {
    logic valid;
    logic one;
    logic noise;
  } tone_t;

  // samples expected in a group of carrier cycles at tone frequency f
  function automatic int group_samples(int fs, int f, int ncyc);
    return (fs * ncyc) / f;
  endfunction

endpackage

// File: rtl/fsk_zc_cycle_timer.sv
module fsk_zc_cycle_timer #(
  parameter int CYC_PER_BIT = 16,
  parameter int CNT_W       = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_valid,
  input  logic             sample_neg,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_count
);
  localparam int XC_W = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam logic [XC_W-1:0]  XC_LAST = XC_W'(CYC_PER_BIT - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_neg;
  logic [XC_W-1:0]  xcnt;
  logic [CNT_W-1:0] scnt;
  logic [CNT_W-1:0] scnt_inc;
  logic             rise;
  logic             closing;

  always_comb begin
    rise     = sample_valid && prev_neg && !sample_neg;
    closing  = rise && (xcnt == XC_LAST);
    scnt_inc = (scnt == CNT_MAX) ? CNT_MAX : scnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_neg   <= 1'b0;
      xcnt       <= '0;
      scnt       <= '0;
      meas_valid <= 1'b0;
      meas_count <= '0;
    end else begin
      meas_valid <= 1'b0;
      if (sample_valid) begin
        prev_neg <= sample_neg;
        if (closing) begin
          meas_valid <= 1'b1;
          meas_count <= scnt_inc;
          scnt       <= '0;
        end else begin
          scnt <= scnt_inc;
        end
        if (rise) xcnt <= closing ? '0 : xcnt + 1'b1;
      end
    end
  end

  // R1
  meas_from_rise_chk: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> $past(sample_valid && !sample_neg));

  // R10
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (scnt == CNT_MAX && sample_valid && !closing) |=> (scnt == CNT_MAX));

endmodule

// File: rtl/fsk_zc_tone_sorter.sv
module fsk_zc_tone_sorter
  import fsk_zc_pkg::*;
#(
  parameter int FS_HZ       = 2_000_000,
  parameter int F_LO_HZ     = 123_200,
  parameter int F_HI_HZ     = 134_200,
  parameter int CYC_PER_BIT = 16,
  parameter int CNT_W       = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_valid,
  input  logic [CNT_W-1:0] meas_count,
  output tone_t            tone
);
  localparam int EXP_LO = group_samples(FS_HZ, F_LO_HZ, CYC_PER_BIT);
  localparam int EXP_HI = group_samples(FS_HZ, F_HI_HZ, CYC_PER_BIT);
  localparam int TOL    = (EXP_LO - EXP_HI + 1) >>> 1;
  localparam logic [CNT_W-1:0] LO_BOT = CNT_W'(EXP_LO - TOL);
  localparam logic [CNT_W-1:0] LO_TOP = CNT_W'(EXP_LO + TOL);
  localparam logic [CNT_W-1:0] HI_BOT = CNT_W'(EXP_HI - TOL);
  localparam logic [CNT_W-1:0] HI_TOP = CNT_W'(EXP_HI + TOL);

  logic in_lo;
  logic in_hi;

  always_comb begin
    in_lo = (meas_count > LO_BOT) && (meas_count < LO_TOP);
    in_hi = (meas_count > HI_BOT) && (meas_count < HI_TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tone <= '0;
    end else begin
      tone.valid <= meas_valid;
      tone.one   <= in_lo;
      tone.noise <= !in_lo && !in_hi;
    end
  end

  // R2
  tone_follows_meas_chk: assert property (@(posedge clk) disable iff (rst)
    tone.valid |-> $past(meas_valid));

endmodule

// File: rtl/fsk_zc_frame_window.sv
module fsk_zc_frame_window
  import fsk_zc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  tone_t              tone,
  output logic               frame_valid,
  output logic [PAY_W-1:0]   payload,
  output logic [CHK_W-1:0]   crc_field
);
  logic [WIN_W-1:0] win;
  logic             hit;

  always_comb begin
    hit = (win[MARK_W-1:0] == SOF_MARK) &&
          (win[HEAD_LSB +: TAG_W] == win[TAIL_LSB +: TAG_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win         <= '0;
      frame_valid <= 1'b0;
      payload     <= '0;
      crc_field   <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (hit) begin
        frame_valid <= 1'b1;
        payload     <= win[PAY_LSB +: PAY_W];
        crc_field   <= win[CHK_LSB +: CHK_W];
        win         <= '0;
      end else if (tone.valid) begin
        if (tone.noise) win <= '0;
        else            win <= {tone.one, win[WIN_W-1:1]};
      end
    end
  end

  // R4
  noise_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    (tone.valid && tone.noise) |=> (win == '0));

  // R5
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (tone.valid && !tone.noise && !hit) |=>
      ((win[WIN_W-1] == $past(tone.one)) && (win[WIN_W-2:0] == $past(win[WIN_W-1:1]))));

  // R6
  mark_seen_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> ($past(win[MARK_W-1:0]) == SOF_MARK));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> ($stable(payload) && $stable(crc_field)));

  // R9
  clear_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (win == '0));

endmodule

// File: rtl/fsk_zc_frame_demod.sv
module fsk_zc_frame_demod #(
  parameter int FS_HZ       = 2_000_000,
  parameter int F_LO_HZ     = 123_200,
  parameter int F_HI_HZ     = 134_200,
  parameter int CYC_PER_BIT = 16,
  parameter int CNT_W       = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sample_valid,
  input  logic        sample_neg,
  output logic        frame_valid,
  output logic [63:0] payload,
  output logic [15:0] crc_field
);
  logic                  meas_valid;
  logic [CNT_W-1:0]      meas_count;
  fsk_zc_pkg::tone_t     tone;

  fsk_zc_cycle_timer #(
    .CYC_PER_BIT (CYC_PER_BIT),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .sample_neg   (sample_neg),
    .meas_valid   (meas_valid),
    .meas_count   (meas_count)
  );

  fsk_zc_tone_sorter #(
    .FS_HZ       (FS_HZ),
    .F_LO_HZ     (F_LO_HZ),
    .F_HI_HZ     (F_HI_HZ),
    .CYC_PER_BIT (CYC_PER_BIT),
    .CNT_W       (CNT_W)
  ) u_sorter (
    .clk        (clk),
    .rst        (rst),
    .meas_valid (meas_valid),
    .meas_count (meas_count),
    .tone       (tone)
  );

  fsk_zc_frame_window u_window (
    .clk         (clk),
    .rst         (rst),
    .tone        (tone),
    .frame_valid (frame_valid),
    .payload     (payload),
    .crc_field   (crc_field)
  );

endmodule

// File: tb/sim_fsk_zc_frame_demod.sv
`timescale 1ns/1ps
module sim_fsk_zc_frame_demod;
  localparam int FS  = 800_000;
  localparam int FLO = 123_200;
  localparam int FHI = 134_200;
  localparam int CYC = 16;
  localparam int CW  = 9;
  localparam int ELO = (FS * CYC) / FLO;     // 103
  localparam int EHI = (FS * CYC) / FHI;     // 95
  localparam int TOL = (ELO - EHI + 1) / 2;  // 4
  localparam int NV  = 7;

  // stimulus / expectation table
  localparam logic [63:0] V_PAY [NV] = '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
    64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0F0F_3C3C_A5A5_1E1E,
    64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF};
  localparam logic [15:0] V_CHK [NV] = '{16'hBEEF, 16'h1234, 16'hBEEF, 16'h4321,
    16'h9A9A, 16'hBEEF, 16'hBEEF};
  localparam logic       V_SB7 [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [7:0] V_END [NV] = '{8'h7E, 8'hFE, 8'h7F, 8'h7E, 8'h7E, 8'h7E, 8'h7E};
  localparam int V_IA [NV] = '{-1, -1, -1, 28, 40, 50, 50};
  localparam int V_TA [NV] = '{0, 0, 0, 100, 92, 99, 615};
  localparam int V_IB [NV] = '{-1, -1, -1, 29, 41, 60, -1};
  localparam int V_TB [NV] = '{0, 0, 0, 98, 106, 107, 0};
  localparam logic V_GAP [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  string tags [NV] = '{"R1 R5 R6 R7", "R6 R7 R8", "R6 R8", "R2 R3", "R2 R3 R5", "R4 R8", "R10 R4"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sv  = 1'b0;
  logic sn  = 1'b0;
  logic        frame_valid;
  logic [63:0] payload;
  logic [15:0] crc_field;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int cyc = 0;
  int gcount = 0;
  logic [63:0] exp_pay = '0;
  logic [15:0] exp_chk = '0;

  always #10 clk = ~clk;

  fsk_zc_frame_demod #(.FS_HZ(FS), .F_LO_HZ(FLO), .F_HI_HZ(FHI),
                       .CYC_PER_BIT(CYC), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .sample_valid(sv), .sample_neg(sn),
    .frame_valid(frame_valid), .payload(payload), .crc_field(crc_field));

  always @(negedge clk) if (frame_valid) pulses++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195_000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 195_000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int classify(int t);
    if (t > ELO - TOL && t < ELO + TOL) return 1;
    if (t > EHI - TOL && t < EHI + TOL) return 0;
    return 2;
  endfunction

  function automatic logic [127:0] build(logic [63:0] pay, logic [15:0] chkf,
                                         logic sb7, logic [7:0] endb);
    logic [127:0] f;
    f = '0;
    f[22:17]   = 6'h3F;
    f[23]      = sb7;
    f[87:24]   = pay;
    f[103:88]  = chkf;
    f[111:104] = endb;
    f[127:112] = 16'hC35A;
    return f;
  endfunction

  task automatic idle(int n);
    sv = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(logic neg, logic gaps);
    sv = 1'b1; sn = neg;
    @(negedge clk);
    if (gaps && (gcount % 4 == 0)) begin
      sv = 1'b0; sn = ~neg;   // strobe low: must be ignored (R1)
      @(negedge clk);
    end
    gcount++;
  endtask

  // 16 carrier cycles whose closing measurement equals t
  task automatic send_group(int t, logic gaps);
    int base = (t - 68) / 15;
    int rem  = (t - 68) % 15;
    for (int c = 0; c < 16; c++) begin
      int p = (c == 15) ? 4 : base + ((c < rem) ? 1 : 0);
      for (int k = 0; k < 4; k++) put(1'b1, gaps);
      for (int k = 0; k < p; k++) put(1'b0, gaps);
    end
  endtask

  task automatic send_frame(logic [127:0] f, int first, int last,
                            int ia, int ta, int ib, int tb, logic gaps);
    for (int k = first; k <= last; k++) begin
      int t = (k == ia) ? ta : (k == ib) ? tb : (f[k] ? ELO : EHI);
      send_group(t, gaps);
    end
  endtask

  initial begin
    logic [127:0] f;
    logic [127:0] ef;
    logic ok;
    int p0;
    int cl;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 frame_valid", {63'd0, frame_valid}, 64'd0);
    chk("R11 payload", payload, 64'd0);
    chk("R11 crc_field", {48'd0, crc_field}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    send_group(200, 1'b0);
    idle(8);

    for (int v = 0; v < NV; v++) begin
      f  = build(V_PAY[v], V_CHK[v], V_SB7[v], V_END[v]);
      ef = f; ok = 1'b1;
      if (V_IA[v] >= 0) begin
        cl = classify(V_TA[v]);
        if (cl == 2) ok = 1'b0; else ef[V_IA[v]] = cl[0];
      end
      if (V_IB[v] >= 0) begin
        cl = classify(V_TB[v]);
        if (cl == 2) ok = 1'b0; else ef[V_IB[v]] = cl[0];
      end
      ok = ok && (ef[23:16] == ef[111:104]);
      p0 = pulses;
      send_frame(f, 0, 127, V_IA[v], V_TA[v], V_IB[v], V_TB[v], V_GAP[v]);
      idle(8);
      if (ok) begin exp_pay = ef[87:24]; exp_chk = ef[103:88]; end
      chk({tags[v], " pulses"}, 64'(pulses - p0), ok ? 64'd1 : 64'd0);
      chk({tags[v], " payload"}, payload, exp_pay);
      chk({tags[v], " crc_field"}, {48'd0, crc_field}, {48'd0, exp_chk});
      send_group(200, 1'b0);
      idle(8);
    end

    // R9: stale history would form a second frame after 40 more bits
    f = build(64'h1234_567E_0000_A5C3, 16'h5555, 1'b0, 8'h7E);
    p0 = pulses;
    send_frame(f, 0, 127, -1, 0, -1, 0, 1'b0);
    idle(8);
    chk("R9 first accept", 64'(pulses - p0), 64'd1);
    p0 = pulses;
    send_frame(128'h0000_0000_0000_0000_0000_0000_007E_0000, 0, 39, -1, 0, -1, 0, 1'b0);
    idle(8);
    chk("R9 no stale frame", 64'(pulses - p0), 64'd0);
    send_group(200, 1'b0);
    idle(8);

    // R11: reset mid-frame discards the 127 bits already collected
    f = build(V_PAY[0], V_CHK[0], 1'b0, 8'h7E);
    p0 = pulses;
    send_frame(f, 0, 126, -1, 0, -1, 0, 1'b0);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    send_frame(f, 127, 127, -1, 0, -1, 0, 1'b0);
    idle(8);
    chk("R11 no frame after reset", 64'(pulses - p0), 64'd0);
    chk("R11 payload cleared", payload, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule